// File: doc/BRIEF.md
# Two-Channel AV Selector Control Slave

This block is the serial control front end of a dual-channel audio/video source selector. It watches an I2C bus through oversampled SCL and SDA inputs and takes part only in write transfers. After a start condition it compares the 7-bit address. The top six bits of that address are fixed at 100100, and the lowest bit comes from a strap input. When the address matches and the transfer is a write, the block takes two control bytes. It acknowledges each one and stores it in the control register of one channel.

Each stored byte is decoded into settings for one channel. The settings are a source select shared by the video and audio switches, a video gain select, and a stereo routing mode. The routing modes are mute, right-to-both, left-to-both and normal. Each byte also sets two general-purpose output levels. SDA is driven only as an open-drain output enable during acknowledge slots. At reset all control registers clear, so every channel starts muted, with the tuner selected, at unity gain and with its output pins low.

Top module: `avsw_i2c_slave`

## Requirements
- R1: The block acknowledges an address byte whose upper seven bits equal 100100 followed by the level of `chip_sel`, and whose lowest bit (R/W) is 0. With `chip_sel` low that is byte 0x90, and with it high that is byte 0x92.
- R2: The block does not acknowledge an address byte with a different address or with R/W at 1. After such a byte it acknowledges nothing and changes no register until the next start condition.
- R3: A start condition is SDA falling while SCL is high. A stop condition is SDA rising while SCL is high. A start condition at any point, including in the middle of a byte, begins a new address phase.
- R4: Bits [1:0] of a channel byte appear unchanged on that channel's `vid_src` and `aud_src` fields. The codes are 0 for tuner, 1 for input 2, 2 for input 3 and 3 for input 4.
- R5: Bits [7:6] of a channel byte set the route codes. On `aud_l_route` and `aud_r_route`, code 0 means mute, 1 means left source and 2 means right source. Mode 00 gives both 0. Mode 01 gives both 2. Mode 10 gives both 1. Mode 11 gives left 1 and right 2.
- R6: Bit [3] of a channel byte appears on that channel's `vid_gain` bit. A 1 selects 6 dB and a 0 selects 0 dB.
- R7: Bit [4] of a channel byte drives `gpo[2c]` and bit [5] drives `gpo[2c+1]`, where c is the channel index.
- R8: The first data byte after an acknowledged address goes to channel 0, which is the lowest field of each output. The second data byte goes to channel 1. Each of these bytes is acknowledged, and its register takes the byte when it is acknowledged.
- R9: A third or later data byte in the same transfer is not acknowledged and leaves both registers unchanged.
- R10: A stop or repeated start in the middle of a transfer keeps any register already written and discards a partly received byte.
- R11: After reset every output is 0. This means tuner selected, 0 dB gain, both routes muted, output pins low and `sda_oe` low.
- R12: `sda_oe` is high through the SCL-high half of each acknowledge slot. It is low again within a few system clocks after that slot's falling SCL edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16 times the SCL rate |
| rst_n | input | 1 | Active-low reset; clears the control registers |
| scl_in | input | 1 | Serial clock line level |
| sda_in | input | 1 | Serial data line level |
| chip_sel | input | 1 | Strap that sets the lowest address bit |
| sda_oe | output | 1 | Pull SDA low when high (open drain) |
| vid_src | output | 4 | Video source code, 2 bits per channel |
| vid_gain | output | 2 | Video gain select, 1 bit per channel |
| aud_src | output | 4 | Audio source code, 2 bits per channel |
| aud_l_route | output | 4 | Left output route code, 2 bits per channel |
| aud_r_route | output | 4 | Right output route code, 2 bits per channel |
| gpo | output | 4 | General-purpose output levels, 2 bits per channel |

## Verification
The bench targets several corner cases. It sends an address with R/W at 1 and addresses that match only under the other strap level. A block that ignored R/W or the strap would acknowledge these and let the following bytes overwrite settings. It sends a third data byte, which would land in a register that does not exist or shift into channel 0 if the byte counter wrapped. It cuts transfers short with a stop or a repeated start in the middle of a byte. A block that kept partial bits or failed to restart its address phase would corrupt channel 1 or miss the next transfer. Each of the four routing modes is checked on both outputs, so a swapped left/right mapping shows up at once.

// File: rtl/avsw_pkg.sv
package avsw_pkg;

   // Route code driven per output: which source feeds it.
   typedef enum logic [1:0] {
      ROUTE_MUTE  = 2'd0,
      ROUTE_LEFT  = 2'd1,
      ROUTE_RIGHT = 2'd2
   } route_e;

   // Stored control fields of one channel (the spare byte bit is dropped).
   typedef struct packed {
      logic [1:0] mode;
      logic       gp_hi;
      logic       gp_lo;
      logic       gain;
      logic [1:0] src;
   } ctl_t;

   localparam int CTL_W = $bits(ctl_t);

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_AACK,
      ST_DATA,
      ST_DACK,
      ST_SKIP
   } link_st_e;

endpackage

// File: rtl/avsw_bus_sync.sv
module avsw_bus_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_in,
   input  logic sda_in,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);

   if (STAGES < 2) begin : g_bad_stages
      $error("avsw_bus_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] scl_ff;
   logic [STAGES-1:0] sda_ff;
   logic              scl_q;
   logic              sda_q;
   logic              scl_now;

   // Idle bus level is high on both lines, so reset to 1 to avoid false events.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_ff <= '1;
         sda_ff <= '1;
         scl_q  <= 1'b1;
         sda_q  <= 1'b1;
      end else begin
         scl_ff <= {scl_ff[STAGES-2:0], scl_in};
         sda_ff <= {sda_ff[STAGES-2:0], sda_in};
         scl_q  <= scl_ff[STAGES-1];
         sda_q  <= sda_ff[STAGES-1];
      end
   end

   assign scl_now   = scl_ff[STAGES-1];
   assign sda_s     = sda_ff[STAGES-1];
   assign scl_rise  = scl_now & ~scl_q;
   assign scl_fall  = ~scl_now & scl_q;
   assign start_det = scl_now & scl_q & sda_q & ~sda_s;
   assign stop_det  = scl_now & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/avsw_link.sv
module avsw_link
   import avsw_pkg::*;
#(
   parameter logic [5:0] ADDR_HI = 6'b100100,
   parameter int         NUM_CH  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sda_s,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              start_det,
   input  logic              stop_det,
   input  logic              addr_lsb,
   output logic              sda_oe,
   output logic [NUM_CH-1:0] wr_stb,
   output ctl_t              wr_ctl
);

   localparam int IDX_W = $clog2(NUM_CH + 1);

   if (NUM_CH < 1) begin : g_bad_ch
      $error("avsw_link: NUM_CH must be at least 1");
   end

   link_st_e         state;
   logic [3:0]       bitcnt;
   logic [7:0]       shreg;
   logic [IDX_W-1:0] idx;
   logic             addr_hit;
   logic             byte_done;

   assign addr_hit  = (shreg[7:1] == {ADDR_HI, addr_lsb}) && !shreg[0];
   assign byte_done = scl_fall && (bitcnt == 4'd8);
   assign wr_ctl    = '{mode: shreg[7:6], gp_hi: shreg[5], gp_lo: shreg[4],
                        gain: shreg[3], src: shreg[1:0]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         bitcnt <= '0;
         shreg  <= '0;
         idx    <= '0;
         sda_oe <= 1'b0;
         wr_stb <= '0;
      end else begin
         wr_stb <= '0;
         if (start_det) begin
            state  <= ST_ADDR;
            bitcnt <= '0;
            idx    <= '0;
            sda_oe <= 1'b0;
         end else if (stop_det) begin
            state  <= ST_IDLE;
            sda_oe <= 1'b0;
         end else begin
            case (state)
               ST_ADDR, ST_DATA: begin
                  if (scl_rise && bitcnt != 4'd8) begin
                     shreg  <= {shreg[6:0], sda_s};
                     bitcnt <= bitcnt + 4'd1;
                  end
                  if (byte_done) begin
                     if (state == ST_ADDR) begin
                        if (addr_hit) begin
                           state  <= ST_AACK;
                           sda_oe <= 1'b1;
                        end else begin
                           state <= ST_SKIP;
                        end
                     end else if (int'(idx) < NUM_CH) begin
                        state  <= ST_DACK;
                        sda_oe <= 1'b1;
                        for (int c = 0; c < NUM_CH; c++) begin
                           wr_stb[c] <= (int'(idx) == c);
                        end
                     end else begin
                        state <= ST_SKIP;
                     end
                  end
               end
               ST_AACK, ST_DACK: begin
                  if (scl_fall) begin
                     sda_oe <= 1'b0;
                     bitcnt <= '0;
                     state  <= ST_DATA;
                     if (state == ST_DACK) idx <= idx + 1'b1;
                  end
               end
               default: ;
            endcase
         end
      end
   end

   // R12: the acknowledge drive only begins right after a falling SCL edge
   assert_oe_after_fall_R12: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_oe) |-> $past(scl_fall));

   // R3: a start always abandons any drive and reopens the address phase
   assert_start_restarts_R3: assert property (@(posedge clk) disable iff (!rst_n)
      start_det |=> (!sda_oe && state == ST_ADDR && bitcnt == 4'd0));

   // R10: a stop returns to idle with the line released
   assert_stop_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_det && !start_det) |=> (state == ST_IDLE && !sda_oe));

   // R8: a register write happens only together with a fresh acknowledge
   assert_write_with_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb != '0) |-> (sda_oe && !$past(sda_oe) && $onehot0(wr_stb)));

   // R2 / R9: an ignored transfer never drives the line
   assert_skip_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_SKIP) |=> (!sda_oe || $past(start_det)));

endmodule

// File: rtl/avsw_ctrl_bank.sv
module avsw_ctrl_bank
   import avsw_pkg::*;
#(
   parameter int NUM_CH = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] wr_stb,
   input  ctl_t              wr_ctl,
   output ctl_t              regs_q [NUM_CH]
);

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)         regs_q[c] <= '0;
         else if (wr_stb[c]) regs_q[c] <= wr_ctl;
      end

      // R10: without a write strobe the stored setting never moves
      assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
         !wr_stb[c] |=> $stable(regs_q[c]));
   end

endmodule

// File: rtl/avsw_chan_decode.sv
module avsw_chan_decode
   import avsw_pkg::*;
(
   input  ctl_t       ctl,
   output logic [1:0] vid_src,
   output logic       vid_gain,
   output logic [1:0] aud_src,
   output route_e     route_l,
   output route_e     route_r,
   output logic [1:0] gpo
);

   assign vid_src  = ctl.src;
   assign aud_src  = ctl.src;
   assign vid_gain = ctl.gain;
   assign gpo      = {ctl.gp_hi, ctl.gp_lo};

   always_comb begin
      unique case (ctl.mode)
         2'b00:   begin route_l = ROUTE_MUTE;  route_r = ROUTE_MUTE;  end
         2'b01:   begin route_l = ROUTE_RIGHT; route_r = ROUTE_RIGHT; end
         2'b10:   begin route_l = ROUTE_LEFT;  route_r = ROUTE_LEFT;  end
         default: begin route_l = ROUTE_LEFT;  route_r = ROUTE_RIGHT; end
      endcase
   end

   // R5: a left output never carries the right source unless both are forced right
   always_comb begin
      assert_route_consistent_R5: assert (!(route_l == ROUTE_RIGHT && route_r != ROUTE_RIGHT));
   end

endmodule

// File: rtl/avsw_i2c_slave.sv
module avsw_i2c_slave
   import avsw_pkg::*;
#(
   parameter logic [5:0] ADDR_HI     = 6'b100100,
   parameter int         NUM_CH      = 2,
   parameter int         SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                scl_in,
   input  logic                sda_in,
   input  logic                chip_sel,
   output logic                sda_oe,
   output logic [2*NUM_CH-1:0] vid_src,
   output logic [NUM_CH-1:0]   vid_gain,
   output logic [2*NUM_CH-1:0] aud_src,
   output logic [2*NUM_CH-1:0] aud_l_route,
   output logic [2*NUM_CH-1:0] aud_r_route,
   output logic [2*NUM_CH-1:0] gpo
);

   logic              sda_s;
   logic              scl_rise;
   logic              scl_fall;
   logic              start_det;
   logic              stop_det;
   logic [NUM_CH-1:0] wr_stb;
   ctl_t              wr_ctl;
   ctl_t              regs_q [NUM_CH];

   avsw_bus_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_in    (scl_in),
      .sda_in    (sda_in),
      .sda_s     (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det)
   );

   avsw_link #(.ADDR_HI(ADDR_HI), .NUM_CH(NUM_CH)) i_link (
      .clk       (clk),
      .rst_n     (rst_n),
      .sda_s     (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det),
      .addr_lsb  (chip_sel),
      .sda_oe    (sda_oe),
      .wr_stb    (wr_stb),
      .wr_ctl    (wr_ctl)
   );

   avsw_ctrl_bank #(.NUM_CH(NUM_CH)) i_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_stb (wr_stb),
      .wr_ctl (wr_ctl),
      .regs_q (regs_q)
   );

   for (genvar c = 0; c < NUM_CH; c++) begin : g_dec
      route_e rl;
      route_e rr;
      avsw_chan_decode i_dec (
         .ctl      (regs_q[c]),
         .vid_src  (vid_src[2*c +: 2]),
         .vid_gain (vid_gain[c]),
         .aud_src  (aud_src[2*c +: 2]),
         .route_l  (rl),
         .route_r  (rr),
         .gpo      (gpo[2*c +: 2])
      );
      assign aud_l_route[2*c +: 2] = rl;
      assign aud_r_route[2*c +: 2] = rr;
   end

endmodule

// File: tb/test_avsw_i2c_slave.sv
`timescale 1ns/1ps
module test_avsw_i2c_slave;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl = 1'b1;
   logic       sda_m = 1'b1;
   logic       chip_sel = 1'b0;
   logic       sda_oe;
   logic [3:0] vid_src;
   logic [1:0] vid_gain;
   logic [3:0] aud_src;
   logic [3:0] aud_l_route;
   logic [3:0] aud_r_route;
   logic [3:0] gpo;
   logic       sda_line;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;
   logic [7:0] exp_reg [2];
   logic [7:0] txb [4];

   always #4 clk = ~clk;   // 125 MHz

   assign sda_line = sda_m & ~sda_oe;

   avsw_i2c_slave i_avsw_i2c_slave (
      .clk         (clk),
      .rst_n       (rst_n),
      .scl_in      (scl),
      .sda_in      (sda_line),
      .chip_sel    (chip_sel),
      .sda_oe      (sda_oe),
      .vid_src     (vid_src),
      .vid_gain    (vid_gain),
      .aud_src     (aud_src),
      .aud_l_route (aud_l_route),
      .aud_r_route (aud_r_route),
      .gpo         (gpo)
   );

   task automatic wclk(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(string req, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic int exp_left(logic [1:0] m);
      if (m == 2'b00) return 0;
      if (m == 2'b01) return 2;
      return 1;
   endfunction

   function automatic int exp_right(logic [1:0] m);
      if (m == 2'b00) return 0;
      if (m == 2'b10) return 1;
      return 2;
   endfunction

   function automatic int addr_ok(logic [7:0] a, logic cs);
      return (a[7:1] == {6'b100100, cs} && !a[0]) ? 1 : 0;
   endfunction

   task automatic check_outs(string req);
      for (int c = 0; c < 2; c++) begin
         logic [7:0] b;
         b = exp_reg[c];
         chk({req, " R4"}, "vid_src", int'(vid_src[2*c +: 2]), int'(b[1:0]));
         chk({req, " R4"}, "aud_src", int'(aud_src[2*c +: 2]), int'(b[1:0]));
         chk({req, " R6"}, "vid_gain", int'(vid_gain[c]), int'(b[3]));
         chk({req, " R7"}, "gpo", int'(gpo[2*c +: 2]), int'({b[5], b[4]}));
         chk({req, " R5"}, "route_l", int'(aud_l_route[2*c +: 2]), exp_left(b[7:6]));
         chk({req, " R5"}, "route_r", int'(aud_r_route[2*c +: 2]), exp_right(b[7:6]));
      end
   endtask

   task automatic i2c_start();
      sda_m = 1'b1; wclk(10);
      scl = 1'b1;   wclk(10);
      sda_m = 1'b0; wclk(10);
      scl = 1'b0;   wclk(10);
   endtask

   task automatic i2c_stop();
      scl = 1'b0;   sda_m = 1'b0; wclk(10);
      scl = 1'b1;   wclk(10);
      sda_m = 1'b1; wclk(20);
   endtask

   task automatic i2c_bits(logic [7:0] b, int n);
      for (int i = 7; i > 7 - n; i--) begin
         sda_m = b[i]; wclk(10);
         scl = 1'b1;   wclk(20);
         scl = 1'b0;   wclk(10);
      end
   endtask

   // Sends a full byte; returns 1 when the slave pulled SDA low in the ack slot.
   task automatic i2c_byte(logic [7:0] b, output int acked);
      i2c_bits(b, 8);
      sda_m = 1'b1; wclk(10);
      scl = 1'b1;   wclk(10);
      acked = (sda_line == 1'b0) ? 1 : 0;
      wclk(10);
      scl = 1'b0;   wclk(10);
      chk("R12", "sda_oe released after ack", int'(sda_oe), 0);
   endtask

   // Full write transfer with n data bytes from txb, expected model updated.
   task automatic xfer(logic [7:0] a, int n, string req);
      int ack;
      int ok;
      ok = addr_ok(a, chip_sel);
      i2c_start();
      i2c_byte(a, ack);
      chk({req, " R1"}, "address ack", ack, ok);
      for (int k = 0; k < n; k++) begin
         int e;
         i2c_byte(txb[k], ack);
         e = (ok == 1 && k < 2) ? 1 : 0;
         chk({req, (k >= 2) ? " R9" : " R8"}, "data ack", ack, e);
         if (e == 1) exp_reg[k] = txb[k];
      end
      i2c_stop();
      wclk(20);
      check_outs(req);
   endtask

   initial begin
      int ack;
      logic [7:0] a;
      void'($urandom(32'd4242));
      exp_reg[0] = '0;
      exp_reg[1] = '0;
      wclk(5);
      rst_n = 1'b1;
      wclk(5);

      // R11: reset state
      chk("R11", "sda_oe after reset", int'(sda_oe), 0);
      check_outs("R11");

      // R1 / R8: basic write with chip_sel low, all four routing modes
      txb[0] = 8'b0000_1001; txb[1] = 8'b0111_0010;
      xfer(8'h90, 2, "R1 basic");
      txb[0] = 8'b1010_0111; txb[1] = 8'b1100_1000;
      xfer(8'h90, 2, "R5 modes");

      // R2: read bit set, then wrong strap address
      txb[0] = 8'hFF; txb[1] = 8'hFF; txb[2] = 8'hFF;
      xfer(8'h91, 3, "R2 read");
      xfer(8'h92, 2, "R2 strap");

      // R1: chip_sel high selects 0x92
      chip_sel = 1'b1;
      txb[0] = 8'h5B; txb[1] = 8'hA6;
      xfer(8'h92, 2, "R1 cs_hi");
      xfer(8'h90, 2, "R2 cs_hi");

      // R9: third byte refused
      txb[0] = 8'h3C; txb[1] = 8'hC3; txb[2] = 8'h00;
      xfer(8'h92, 3, "R9 third");

      // R10 / R3: repeated start in the middle of the second data byte
      chip_sel = 1'b0;
      i2c_start();
      i2c_byte(8'h90, ack);
      chk("R10", "address ack", ack, 1);
      i2c_byte(8'h81, ack);
      chk("R10", "first byte ack", ack, 1);
      exp_reg[0] = 8'h81;
      i2c_bits(8'h00, 3);
      i2c_start();
      i2c_byte(8'h90, ack);
      chk("R3", "ack after repeated start", ack, 1);
      i2c_byte(8'h42, ack);
      chk("R3", "byte after repeated start", ack, 1);
      exp_reg[0] = 8'h42;
      i2c_stop();
      wclk(20);
      check_outs("R10 rs");

      // R10: stop in the middle of the first data byte
      i2c_start();
      i2c_byte(8'h90, ack);
      chk("R10", "address ack", ack, 1);
      i2c_bits(8'hFF, 4);
      i2c_stop();
      wclk(20);
      check_outs("R10 stop");

      // R2 / R3: ignored transfer, then repeated start with a good address
      i2c_start();
      i2c_byte(8'h94, ack);
      chk("R2", "mismatch nack", ack, 0);
      i2c_byte(8'h90, ack);
      chk("R2", "ignored byte nack", ack, 0);
      i2c_start();
      i2c_byte(8'h90, ack);
      chk("R3", "ack after restart", ack, 1);
      i2c_byte(8'hE5, ack);
      chk("R8", "ack", ack, 1);
      exp_reg[0] = 8'hE5;
      i2c_stop();
      wclk(20);
      check_outs("R2 restart");

      // Random transfers
      for (int t = 0; t < 24; t++) begin
         int n;
         chip_sel = 1'($urandom_range(0, 1));
         a = {6'b100100, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 3) == 0)};
         n = $urandom_range(1, 3);
         for (int k = 0; k < 3; k++) txb[k] = 8'($urandom());
         xfer(a, n, "R4 random");
      end

      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      done = 1'b1;
      $finish;
   end

   initial begin
      repeat (180000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog timeout actual=1 expected=0");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule